// File: doc/BRIEF.md
# Watchdog Supervisor with Reset Pulse Generator

This block supervises a processor through a kick line that software must toggle regularly. The block counts periods of a timebase that arrives as a one-cycle tick-enable. It drives an active-low system reset and an active-low watchdog status flag. Two select pins choose one of three timing sets. Each set gives a normal kick window, a longer start-up window, and a fixed reset pulse length, all measured in ticks.

After any reset pulse, the block applies the long start-up window. This gives software time to initialise before it has to kick. The first kick edge switches the block to the normal window, and every later edge, rising or falling, restarts the count. When a window runs out, the block starts a reset pulse and latches the status flag low. The flag stays low until a kick edge is accepted. A supply-low input from an external comparator holds the block in reset for as long as it is asserted and forces the status flag high. When that input clears, one full reset pulse follows.

Top module: `wdSupervisor`

## Requirements
- R1: While `rstN` is low, `resetN` is low and `wdStatusN` is high. After `rstN` goes high, `resetN` stays low for exactly 512 ticks and then goes high.
- R2: Mode decode. `oscSel`=0 selects 1024-tick kick and 4096-tick start-up windows. `oscSel`=1 with `oscIn`=0 selects 1024 and 16384 ticks. `oscSel`=1 with `oscIn`=1 selects 16384 ticks for both windows.
- R3: From the end of each reset pulse until the first accepted kick edge, the start-up window is in force.
- R4: Every rising or falling edge on `wdIn` restarts the count at zero and selects the kick window. The edge passes a two-flop synchroniser, so the restart lands on the third clock edge after the change.
- R5: When a window expires, `resetN` and `wdStatusN` both go low on the same clock edge. The reset pulse lasts 512 ticks and is followed by the start-up window.
- R6: `wdStatusN` stays low through the reset pulse and the start-up window. It returns high only on an accepted kick edge or on supply-low.
- R7: Edges on `wdIn` during a reset pulse are ignored. They neither raise `wdStatusN` nor shorten the start-up window that follows.
- R8: While `supplyLow` is high, `resetN` is low from the next clock edge and `wdStatusN` is high. After `supplyLow` falls, a full 512-tick pulse runs before `resetN` goes high.
- R9: The select pins are read only when the count restarts. A change partway through a window does not alter that window.
- R10: Counters advance only on cycles with `tickEn` high. Without ticks, neither a window nor a reset pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| tickEn | input | 1 | One-cycle timebase tick |
| wdIn | input | 1 | Kick line from software, asynchronous |
| oscSel | input | 1 | Timing select: 0 external set, 1 internal sets |
| oscIn | input | 1 | Internal set choice: 0 short kick window, 1 long |
| supplyLow | input | 1 | Supply below threshold, synchronous to clk |
| resetN | output | 1 | Active-low reset to the system |
| wdStatusN | output | 1 | Active-low watchdog-expired flag |

## Verification
A change on `wdIn` made between edges restarts the count on the third rising edge after it, and the expiry follows N ticks later. With ticks every cycle, the drop of `resetN` is due exactly 3+N edges after the toggle. A reset pulse or a window that starts on an edge ends exactly 512 or N edges later, and `supplyLow` takes effect one edge after it is driven. The bench drives and samples on falling edges and counts rising edges from the starting event. It checks the output one edge before the due edge, expecting the old level, and again on the due edge, expecting the new level, so an off-by-one in any stage is caught.

// File: rtl/wdSupPkg.sv
package wdSupPkg;

  typedef enum logic [1:0] {
    MODE_EXT       = 2'd0,
    MODE_INT_SHORT = 2'd1,
    MODE_INT_LONG  = 2'd2
  } wdModeE;

  typedef enum logic [1:0] {
    PH_RESET = 2'd0,
    PH_INIT  = 2'd1,
    PH_RUN   = 2'd2
  } wdPhaseE;

  // control-to-datapath strobes
  typedef struct packed {
    logic restart;   // clear the tick counter
    logic advance;   // count one tick
    logic selInit;   // latch the start-up window of the current mode
    logic selNorm;   // latch the kick window of the current mode
  } wdStrobeT;

endpackage

// File: rtl/wdEdgeSync.sv
module wdEdgeSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic wdIn,
  output logic edgePulse
);

  logic [STAGES:0] chain;
  logic prevQ;

  assign chain[0] = wdIn;

  for (genvar i = 0; i < STAGES; i++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[i+1] <= 1'b0;
      else       chain[i+1] <= chain[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= chain[STAGES];
  end

  assign edgePulse = chain[STAGES] ^ prevQ;

endmodule

// File: rtl/wdModeDecode.sv
module wdModeDecode import wdSupPkg::*; (
  input  logic   oscSel,
  input  logic   oscIn,
  output wdModeE mode
);

  always_comb begin
    if (!oscSel)    mode = MODE_EXT;
    else if (oscIn) mode = MODE_INT_LONG;
    else            mode = MODE_INT_SHORT;
  end

endmodule

// File: rtl/wdDatapath.sv
module wdDatapath import wdSupPkg::*; #(
  parameter int RST_TICKS = 512,
  parameter int EXT_NORM  = 1024,
  parameter int EXT_INIT  = 4096,
  parameter int ISH_NORM  = 1024,
  parameter int ISH_INIT  = 16384,
  parameter int ILG_NORM  = 16384,
  parameter int ILG_INIT  = 16384
) (
  input  logic     clk,
  input  logic     rstN,
  input  wdModeE   mode,
  input  wdStrobeT strobe,
  output logic     pulseDone,
  output logic     limitHit
);

  localparam int PEAK_A = (EXT_NORM > EXT_INIT) ? EXT_NORM : EXT_INIT;
  localparam int PEAK_B = (ISH_NORM > ISH_INIT) ? ISH_NORM : ISH_INIT;
  localparam int PEAK_C = (ILG_NORM > ILG_INIT) ? ILG_NORM : ILG_INIT;
  localparam int PEAK_D = (PEAK_A > PEAK_B) ? PEAK_A : PEAK_B;
  localparam int PEAK_E = (PEAK_C > RST_TICKS) ? PEAK_C : RST_TICKS;
  localparam int PEAK   = (PEAK_D > PEAK_E) ? PEAK_D : PEAK_E;
  localparam int CNT_W  = (PEAK > 2) ? $clog2(PEAK) : 1;
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_TICKS - 1);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] lastQ;
  logic [CNT_W-1:0] normLast;
  logic [CNT_W-1:0] initLast;

  always_comb begin
    unique case (mode)
      MODE_INT_SHORT: begin
        normLast = CNT_W'(ISH_NORM - 1);
        initLast = CNT_W'(ISH_INIT - 1);
      end
      MODE_INT_LONG: begin
        normLast = CNT_W'(ILG_NORM - 1);
        initLast = CNT_W'(ILG_INIT - 1);
      end
      default: begin
        normLast = CNT_W'(EXT_NORM - 1);
        initLast = CNT_W'(EXT_INIT - 1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      lastQ  <= CNT_W'(EXT_INIT - 1);
    end else begin
      if (strobe.restart)      countQ <= '0;
      else if (strobe.advance) countQ <= countQ + CNT_W'(1);
      if (strobe.selInit)      lastQ  <= initLast;
      else if (strobe.selNorm) lastQ  <= normLast;
    end
  end

  assign pulseDone = (countQ == RST_LAST);
  assign limitHit  = (countQ == lastQ);

endmodule

// File: rtl/wdControl.sv
module wdControl import wdSupPkg::*; (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickEn,
  input  logic     edgePulse,
  input  logic     supplyLow,
  input  logic     pulseDone,
  input  logic     limitHit,
  output wdStrobeT strobe,
  output logic     resetN,
  output logic     wdStatusN
);

  wdPhaseE phaseQ, phaseNext;
  logic    statusQ, statusNext;

  always_comb begin
    phaseNext  = phaseQ;
    statusNext = statusQ;
    strobe     = '0;
    if (supplyLow) begin
      phaseNext      = PH_RESET;
      statusNext     = 1'b1;
      strobe.restart = 1'b1;
    end else begin
      unique case (phaseQ)
        PH_RESET: begin
          if (tickEn) begin
            if (pulseDone) begin
              phaseNext      = PH_INIT;
              strobe.restart = 1'b1;
              strobe.selInit = 1'b1;
            end else begin
              strobe.advance = 1'b1;
            end
          end
        end
        default: begin
          if (edgePulse) begin
            phaseNext      = PH_RUN;
            statusNext     = 1'b1;
            strobe.restart = 1'b1;
            strobe.selNorm = 1'b1;
          end else if (tickEn) begin
            if (limitHit) begin
              phaseNext      = PH_RESET;
              statusNext     = 1'b0;
              strobe.restart = 1'b1;
            end else begin
              strobe.advance = 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= PH_RESET;
      statusQ <= 1'b1;
    end else begin
      phaseQ  <= phaseNext;
      statusQ <= statusNext;
    end
  end

  assign resetN    = (phaseQ != PH_RESET);
  assign wdStatusN = statusQ;

endmodule

// File: rtl/wdSupervisor.sv
module wdSupervisor import wdSupPkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_TICKS   = 512,
  parameter int EXT_NORM    = 1024,
  parameter int EXT_INIT    = 4096,
  parameter int ISH_NORM    = 1024,
  parameter int ISH_INIT    = 16384,
  parameter int ILG_NORM    = 16384,
  parameter int ILG_INIT    = 16384
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic wdIn,
  input  logic oscSel,
  input  logic oscIn,
  input  logic supplyLow,
  output logic resetN,
  output logic wdStatusN
);

  wdModeE   mode;
  wdStrobeT strobe;
  logic     edgePulse;
  logic     pulseDone;
  logic     limitHit;

  wdEdgeSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .wdIn(wdIn), .edgePulse(edgePulse)
  );

  wdModeDecode uDecode (
    .oscSel(oscSel), .oscIn(oscIn), .mode(mode)
  );

  wdDatapath #(
    .RST_TICKS(RST_TICKS), .EXT_NORM(EXT_NORM), .EXT_INIT(EXT_INIT),
    .ISH_NORM(ISH_NORM), .ISH_INIT(ISH_INIT),
    .ILG_NORM(ILG_NORM), .ILG_INIT(ILG_INIT)
  ) uData (
    .clk(clk), .rstN(rstN), .mode(mode), .strobe(strobe),
    .pulseDone(pulseDone), .limitHit(limitHit)
  );

  wdControl uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .edgePulse(edgePulse),
    .supplyLow(supplyLow), .pulseDone(pulseDone), .limitHit(limitHit),
    .strobe(strobe), .resetN(resetN), .wdStatusN(wdStatusN)
  );

endmodule

// File: rtl/wdSupervisorChk.sv
module wdSupervisorChk (
  input logic clk,
  input logic rstN,
  input logic tickEn,
  input logic wdIn,
  input logic supplyLow,
  input logic resetN,
  input logic wdStatusN
);

  AST_SUPPLY_FORCES_RESET: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |=> (!resetN && wdStatusN)); // R8

  AST_FLAG_FALLS_WITH_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdStatusN) |-> $fell(resetN)); // R5

  AST_FLAG_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdStatusN) |-> ($past(supplyLow) || ($past(wdIn, 3) != $past(wdIn, 4)))); // R6

  AST_NO_TICK_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    (resetN && !tickEn && !supplyLow) |=> resetN); // R10

  AST_NO_TICK_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!resetN && !tickEn && !supplyLow) |=> !resetN); // R10

endmodule

bind wdSupervisor wdSupervisorChk chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wdIn(wdIn),
  .supplyLow(supplyLow), .resetN(resetN), .wdStatusN(wdStatusN)
);

// File: tb/wdSupervisor_test.sv
module wdSupervisor_test;

  logic clk = 1'b0;
  logic rstN, tickEn, wdIn, oscSel, oscIn, supplyLow;
  logic resetN, wdStatusN;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  wdSupervisor uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wdIn(wdIn),
    .oscSel(oscSel), .oscIn(oscIn), .supplyLow(supplyLow),
    .resetN(resetN), .wdStatusN(wdStatusN)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // reset output falls exactly n edges from the reference point
  task automatic fallAfter(input string req, input int n);
    step(n - 1);
    chk(req, "resetN before expiry", resetN, 1'b1);
    step(1);
    chk(req, "resetN at expiry", resetN, 1'b0);
  endtask

  // reset output rises exactly n edges from the reference point
  task automatic riseAfter(input string req, input int n);
    step(n - 1);
    chk(req, "resetN before release", resetN, 1'b0);
    step(1);
    chk(req, "resetN at release", resetN, 1'b1);
  endtask

  // toggle the kick line and move to the edge where the count restarts
  task automatic kick();
    wdIn = ~wdIn;
    step(3);
  endtask

  task automatic testPowerUp();
    step(3);
    chk("R1", "resetN in reset", resetN, 1'b0);
    chk("R1", "flag in reset", wdStatusN, 1'b1);
    rstN = 1'b1;
    riseAfter("R1", 512);
    chk("R1", "flag after pulse", wdStatusN, 1'b1);
  endtask

  task automatic testStartupExpiry();
    fallAfter("R3", 4096);                 // external start-up window (R2)
    chk("R5", "flag at expiry", wdStatusN, 1'b0);
    step(100);
    wdIn = ~wdIn;                          // R7: edge inside the pulse
    step(5);
    chk("R6", "flag low in pulse", wdStatusN, 1'b0);
    riseAfter("R5", 407);
    chk("R6", "flag low in start-up", wdStatusN, 1'b0);
    fallAfter("R7", 4096);                 // ignored edge left the full window
    riseAfter("R5", 512);
  endtask

  task automatic testKicks();
    step(10);
    wdIn = ~wdIn;
    step(2);
    chk("R6", "flag before edge lands", wdStatusN, 1'b0);
    step(1);
    chk("R6", "flag after kick", wdStatusN, 1'b1);
    fallAfter("R4", 1024);
    riseAfter("R5", 512);
    kick(); step(1000);
    kick(); step(1000);
    kick(); step(1000);
    chk("R4", "both edge polarities restart", resetN, 1'b1);
    fallAfter("R4", 24);
    riseAfter("R5", 512);
  endtask

  task automatic testModeLatch();
    kick();
    step(500);
    oscSel = 1'b1; oscIn = 1'b1;           // change mid-window
    fallAfter("R9", 524);
    riseAfter("R5", 512);
    fallAfter("R2", 16384);                // long start-up window
    riseAfter("R5", 512);
    kick();
    fallAfter("R2", 16384);                // long kick window
    step(10);
    oscIn = 1'b0;                          // short internal set
    riseAfter("R5", 502);
    fallAfter("R2", 16384);                // short start-up window
    riseAfter("R5", 512);
    kick();
    fallAfter("R2", 1024);                 // short kick window
  endtask

  task automatic testSupply();
    step(20);
    chk("R8", "flag low before supply event", wdStatusN, 1'b0);
    supplyLow = 1'b1;
    step(1);
    chk("R8", "resetN on supply low", resetN, 1'b0);
    chk("R8", "flag forced high", wdStatusN, 1'b1);
    step(600);
    chk("R8", "reset held", resetN, 1'b0);
    supplyLow = 1'b0;
    riseAfter("R8", 512);
    kick();
    step(100);
    supplyLow = 1'b1;
    step(1);
    chk("R8", "resetN from running", resetN, 1'b0);
    supplyLow = 1'b0;
    riseAfter("R8", 512);
  endtask

  task automatic testTickGate();
    kick();
    step(1000);
    tickEn = 1'b0;
    step(300);
    chk("R10", "window frozen", resetN, 1'b1);
    tickEn = 1'b1;
    fallAfter("R10", 24);
    tickEn = 1'b0;
    step(1000);
    chk("R10", "pulse frozen", resetN, 1'b0);
    tickEn = 1'b1;
    riseAfter("R10", 512);
  endtask

  initial begin
    rstN = 1'b0; tickEn = 1'b1; wdIn = 1'b0;
    oscSel = 1'b0; oscIn = 1'b0; supplyLow = 1'b0;
    testPowerUp();
    testStartupExpiry();
    testKicks();
    testModeLatch();
    testSupply();
    testTickGate();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule